// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block watches a received Ethernet frame as a stream of bytes. Each byte comes with a valid strobe, a start marker and an end marker. When the frame ends, the block gives two results: whether the frame is kept, which means it is committed to the receive buffer, and whether it raises a receive-event interrupt. The decision rests on two independent tests, and a frame must pass both.

The first is the address test. The block captures the six destination-address bytes and sorts the address into individual, multicast or broadcast. It then checks the address against a programmed station address, a 64-entry hash table and a promiscuous setting. The second is the frame-class test. The block counts the frame length to find runt and oversize frames. It combines these with the CRC status supplied at the end of the frame. Every condition the frame shows must have its own class enable set.

While the frame arrives, bytes are copied to a buffer-write port. Copying stops after the maximum legal length, so oversize frames are truncated. The CRC computation itself comes from outside: the caller supplies the CRC-good flag and the upper bits of the CRC computed over the destination address.

Top module: `rxf_accept_filter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `frm_done`, `frm_accept`, `frm_irq` and `buf_valid` are low.
- R2: `frm_done` pulses high for exactly one cycle, on the cycle after a byte with `rx_valid` and `rx_eof` both high. The status outputs `frm_addr_pass`, `frm_kind`, `frm_runt`, `frm_long` and `frm_crc_bad` keep their values until the next such pulse.
- R3: The first received byte is destination-address byte 0. `frm_kind` reports 2 (broadcast) when all 48 address bits are one. It reports 1 (multicast) when bit 0 of byte 0 is set and the address is not broadcast. Otherwise it reports 0 (individual).
- R4: When `cfg_addr_en[4]` (promiscuous) is set, every frame passes the address test.
- R5: When `cfg_addr_en[0]` is set, an individual frame passes if its 48-bit address equals `cfg_ind_addr`. Address byte k is compared with `cfg_ind_addr[8k+7:8k]`.
- R6: When `cfg_addr_en[3]` is set, every broadcast frame passes the address test.
- R7: The hash hit is `cfg_hash_tbl[rx_da_hash]`, sampled with the end byte. A multicast frame passes on a hit when `cfg_addr_en[2]` is set. An individual frame passes on a hit when `cfg_addr_en[1]` is set.
- R8: Let L be the number of bytes in the frame. `frm_runt` is set when L < MIN_LEN (default 64). `frm_long` is set when L > MAX_LEN (default 1518). `frm_crc_bad` is set when `rx_crc_ok` is low on the end byte.
- R9: `frm_accept` pulses with `frm_done` when two things hold. First, the address test passed. Second, every condition the frame shows has its enable set in `cfg_class_en`: bit 0 good (no runt, no oversize, CRC good), bit 1 bad CRC, bit 2 runt, bit 3 oversize.
- R10: `buf_valid` and `buf_data` repeat each input byte one cycle later, but only for the first MAX_LEN bytes of a frame.
- R11: `frm_irq` pulses with `frm_done` when two things hold. First, the address test passed. Second, at least one condition the frame shows has its bit set in `cfg_irq_en`. The bit order is the same as in `cfg_class_en`.
- R12: A frame with fewer than 6 bytes reports `frm_kind` 0. It passes the address test only when promiscuous mode is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of a frame (qualified by rx_valid) |
| rx_eof | input | 1 | Last byte of a frame (qualified by rx_valid) |
| rx_data | input | 8 | Received byte |
| rx_crc_ok | input | 1 | Frame CRC good, sampled with the end byte |
| rx_da_hash | input | HASH_W | Upper CRC bits over the address, sampled with the end byte |
| cfg_ind_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| cfg_hash_tbl | input | 2**HASH_W | Hash table |
| cfg_addr_en | input | 5 | Address enables: 0 exact, 1 individual hash, 2 multicast hash, 3 broadcast, 4 promiscuous |
| cfg_class_en | input | 4 | Class enables: 0 good, 1 bad CRC, 2 runt, 3 oversize |
| cfg_irq_en | input | 4 | Interrupt enables, same order as cfg_class_en |
| buf_valid | output | 1 | Buffer-write byte strobe |
| buf_data | output | 8 | Buffer-write byte |
| frm_done | output | 1 | End-of-frame result pulse |
| frm_accept | output | 1 | Frame kept (pulse) |
| frm_irq | output | 1 | Receive-event interrupt (pulse) |
| frm_addr_pass | output | 1 | Last frame passed the address test |
| frm_kind | output | 2 | Last frame's address kind |
| frm_runt | output | 1 | Last frame was a runt |
| frm_long | output | 1 | Last frame was oversize |
| frm_crc_bad | output | 1 | Last frame had a bad CRC |

## Verification
The bench builds the filter with MIN_LEN=8 and MAX_LEN=12. With these limits, a sweep of every frame length from 1 to 15 reaches all the boundary cases: frames too short to hold a whole address, runts, both length limits exactly, and truncated oversize frames. That sweep is crossed with all 16 class-enable patterns and both CRC states. A second sweep crosses four address patterns with all 32 address-enable patterns and with a hash hit and a hash miss.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int DA_BYTES = 6;

  // address enable bit positions
  localparam int AE_EXACT   = 0;
  localparam int AE_IHASH   = 1;
  localparam int AE_MHASH   = 2;
  localparam int AE_BCAST   = 3;
  localparam int AE_PROMISC = 4;
  localparam int AE_W       = 5;

  // frame class / interrupt bit positions
  localparam int EC_GOOD = 0;
  localparam int EC_CRC  = 1;
  localparam int EC_RUNT = 2;
  localparam int EC_LONG = 3;
  localparam int EC_W    = 4;

  typedef enum logic [1:0] {
    KIND_IND = 2'd0,
    KIND_MC  = 2'd1,
    KIND_BC  = 2'd2
  } da_kind_e;
endpackage

// File: rtl/rxf_len_track.sv
module rxf_len_track #(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  parameter int CNT_W   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic [7:0]       rx_data,
  output logic [CNT_W-1:0] idx,
  output logic             is_runt,
  output logic             is_long,
  output logic             buf_valid,
  output logic [7:0]       buf_data
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;

  assign idx     = rx_sof ? '0 : cnt_q;
  assign len     = idx + CNT_W'(1);
  assign is_runt = len < CNT_W'(MIN_LEN);
  assign is_long = len > CNT_W'(MAX_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (rx_valid) begin
      cnt_q <= (idx >= SAT) ? SAT : idx + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_valid <= 1'b0;
    end else begin
      buf_valid <= rx_valid && (idx < CNT_W'(MAX_LEN));
    end
    buf_data <= rx_data;
  end

  // checker: bytes written to the buffer per frame
  logic             buf_sof_q;
  logic [CNT_W-1:0] out_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_sof_q <= 1'b0;
      out_cnt   <= '0;
    end else begin
      buf_sof_q <= rx_valid && rx_sof;
      if (buf_valid) out_cnt <= buf_sof_q ? CNT_W'(1) : out_cnt + CNT_W'(1);
    end
  end

  // R10
  trunc_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_valid && !buf_sof_q) |-> (out_cnt < CNT_W'(MAX_LEN)));
endmodule

// File: rtl/rxf_da_capture.sv
module rxf_da_capture
  import rxf_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_data,
  input  logic [CNT_W-1:0]      idx,
  output logic [8*DA_BYTES-1:0] da_now,
  output logic                  da_full,
  output da_kind_e              kind
);
  logic [DA_BYTES-1:0][7:0] da_q;
  logic [DA_BYTES-1:0]      wr;

  for (genvar b = 0; b < DA_BYTES; b++) begin : g_byte
    assign wr[b] = rx_valid && (idx == CNT_W'(b));
    assign da_now[8*b +: 8] = wr[b] ? rx_data : da_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      da_q <= '0;
    end else begin
      for (int b = 0; b < DA_BYTES; b++) begin
        if (wr[b]) da_q[b] <= rx_data;
      end
    end
  end

  assign da_full = idx >= CNT_W'(DA_BYTES - 1);

  always_comb begin
    if (!da_full)      kind = KIND_IND;
    else if (&da_now)  kind = KIND_BC;
    else if (da_now[0]) kind = KIND_MC;
    else               kind = KIND_IND;
  end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int HASH_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  eof_stb,
  input  logic [8*DA_BYTES-1:0] da_now,
  input  logic                  da_full,
  input  da_kind_e              kind,
  input  logic [HASH_W-1:0]     da_hash,
  input  logic [8*DA_BYTES-1:0] ind_addr,
  input  logic [2**HASH_W-1:0]  hash_tbl,
  input  logic [AE_W-1:0]       addr_en,
  input  logic [EC_W-1:0]       class_en,
  input  logic [EC_W-1:0]       irq_en,
  input  logic                  crc_ok,
  input  logic                  is_runt,
  input  logic                  is_long,
  output logic                  frm_done,
  output logic                  frm_accept,
  output logic                  frm_irq,
  output logic                  frm_addr_pass,
  output logic [1:0]            frm_kind,
  output logic                  frm_runt,
  output logic                  frm_long,
  output logic                  frm_crc_bad
);
  logic            hash_hit;
  logic            is_ind;
  logic            exact_hit;
  logic            addr_pass;
  logic            class_pass;
  logic            irq_now;
  logic [EC_W-1:0] ev;

  assign hash_hit  = hash_tbl[da_hash];
  assign is_ind    = (kind == KIND_IND);
  assign exact_hit = (da_now == ind_addr);

  always_comb begin
    addr_pass = addr_en[AE_PROMISC];
    if (da_full) begin
      addr_pass = addr_pass
        | (addr_en[AE_EXACT] & is_ind & exact_hit)
        | (addr_en[AE_IHASH] & is_ind & hash_hit)
        | (addr_en[AE_MHASH] & (kind == KIND_MC) & hash_hit)
        | (addr_en[AE_BCAST] & (kind == KIND_BC));
    end
  end

  always_comb begin
    ev          = '0;
    ev[EC_GOOD] = crc_ok & ~is_runt & ~is_long;
    ev[EC_CRC]  = ~crc_ok;
    ev[EC_RUNT] = is_runt;
    ev[EC_LONG] = is_long;
  end

  assign class_pass = ((ev & ~class_en) == '0);
  assign irq_now    = addr_pass & (|(ev & irq_en));

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_done      <= 1'b0;
      frm_accept    <= 1'b0;
      frm_irq       <= 1'b0;
      frm_addr_pass <= 1'b0;
      frm_kind      <= 2'd0;
      frm_runt      <= 1'b0;
      frm_long      <= 1'b0;
      frm_crc_bad   <= 1'b0;
    end else begin
      frm_done   <= eof_stb;
      frm_accept <= eof_stb & addr_pass & class_pass;
      frm_irq    <= eof_stb & irq_now;
      if (eof_stb) begin
        frm_addr_pass <= addr_pass;
        frm_kind      <= kind;
        frm_runt      <= is_runt;
        frm_long      <= is_long;
        frm_crc_bad   <= ~crc_ok;
      end
    end
  end

  // R11
  irq_needs_pass_chk: assert property (@(posedge clk) disable iff (rst)
    frm_irq |-> (frm_addr_pass && frm_done));
  // R9
  accept_needs_pass_chk: assert property (@(posedge clk) disable iff (rst)
    frm_accept |-> (frm_addr_pass && frm_done));
  // R8
  runt_long_excl_chk: assert property (@(posedge clk) disable iff (rst)
    frm_done |-> !(frm_runt && frm_long));
  // R2
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frm_done |-> ($stable(frm_kind) && $stable(frm_addr_pass)));
endmodule

// File: rtl/rxf_accept_filter.sv
module rxf_accept_filter
  import rxf_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  parameter int HASH_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_valid,
  input  logic                  rx_sof,
  input  logic                  rx_eof,
  input  logic [7:0]            rx_data,
  input  logic                  rx_crc_ok,
  input  logic [HASH_W-1:0]     rx_da_hash,
  input  logic [47:0]           cfg_ind_addr,
  input  logic [2**HASH_W-1:0]  cfg_hash_tbl,
  input  logic [4:0]            cfg_addr_en,
  input  logic [3:0]            cfg_class_en,
  input  logic [3:0]            cfg_irq_en,
  output logic                  buf_valid,
  output logic [7:0]            buf_data,
  output logic                  frm_done,
  output logic                  frm_accept,
  output logic                  frm_irq,
  output logic                  frm_addr_pass,
  output logic [1:0]            frm_kind,
  output logic                  frm_runt,
  output logic                  frm_long,
  output logic                  frm_crc_bad
);
  localparam int CNT_W = $clog2(MAX_LEN + 3);

  logic [CNT_W-1:0]      idx;
  logic                  is_runt;
  logic                  is_long;
  logic [8*DA_BYTES-1:0] da_now;
  logic                  da_full;
  da_kind_e              kind;
  logic                  eof_stb;

  assign eof_stb = rx_valid & rx_eof;

  rxf_len_track #(
    .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)
  ) u_len (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .idx(idx), .is_runt(is_runt), .is_long(is_long),
    .buf_valid(buf_valid), .buf_data(buf_data)
  );

  rxf_da_capture #(.CNT_W(CNT_W)) u_da (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .idx(idx), .da_now(da_now), .da_full(da_full), .kind(kind)
  );

  rxf_decide #(.HASH_W(HASH_W)) u_dec (
    .clk(clk), .rst(rst), .eof_stb(eof_stb), .da_now(da_now),
    .da_full(da_full), .kind(kind), .da_hash(rx_da_hash),
    .ind_addr(cfg_ind_addr), .hash_tbl(cfg_hash_tbl),
    .addr_en(cfg_addr_en), .class_en(cfg_class_en), .irq_en(cfg_irq_en),
    .crc_ok(rx_crc_ok), .is_runt(is_runt), .is_long(is_long),
    .frm_done(frm_done), .frm_accept(frm_accept), .frm_irq(frm_irq),
    .frm_addr_pass(frm_addr_pass), .frm_kind(frm_kind),
    .frm_runt(frm_runt), .frm_long(frm_long), .frm_crc_bad(frm_crc_bad)
  );

  // R2
  done_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
    frm_done |-> $past(rx_valid && rx_eof));
  // R4
  promisc_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (eof_stb && cfg_addr_en[4]) |=> frm_addr_pass);
endmodule

// File: tb/test_rxf_accept_filter.sv
`timescale 1ns/1ps
module test_rxf_accept_filter;
  localparam int MIN_L = 8;
  localparam int MAX_L = 12;
  localparam int HW    = 6;
  localparam logic [47:0] IA    = 48'h5544_3322_1100;
  localparam logic [63:0] TBL   = 64'hF0F0_1234_ABCD_0081;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_ok = 0;
  logic [7:0] rx_data = 0;
  logic [HW-1:0] rx_da_hash = 0;
  logic [47:0] cfg_ind_addr = IA;
  logic [63:0] cfg_hash_tbl = TBL;
  logic [4:0] cfg_addr_en = 0;
  logic [3:0] cfg_class_en = 0, cfg_irq_en = 0;
  logic buf_valid, frm_done, frm_accept, frm_irq, frm_addr_pass;
  logic frm_runt, frm_long, frm_crc_bad;
  logic [7:0] buf_data;
  logic [1:0] frm_kind;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  rxf_accept_filter #(.MIN_LEN(MIN_L), .MAX_LEN(MAX_L), .HASH_W(HW)) i_rxf_accept_filter (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_crc_ok(rx_crc_ok), .rx_da_hash(rx_da_hash),
    .cfg_ind_addr(cfg_ind_addr), .cfg_hash_tbl(cfg_hash_tbl),
    .cfg_addr_en(cfg_addr_en), .cfg_class_en(cfg_class_en), .cfg_irq_en(cfg_irq_en),
    .buf_valid(buf_valid), .buf_data(buf_data), .frm_done(frm_done),
    .frm_accept(frm_accept), .frm_irq(frm_irq), .frm_addr_pass(frm_addr_pass),
    .frm_kind(frm_kind), .frm_runt(frm_runt), .frm_long(frm_long),
    .frm_crc_bad(frm_crc_bad)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(input logic [47:0] da, input int i);
    if (i < 6) return da[8*i +: 8];
    return 8'(i * 7 + 3);
  endfunction

  task automatic run_frame(input logic [47:0] da, input int len, input bit crc,
                           input logic [HW-1:0] h, input logic [4:0] ae,
                           input logic [3:0] ce, input logic [3:0] ie);
    int bc = 0;
    int bad = 0;
    bit full, runt, lng, hit, pass, cls, acc, irq;
    int kind;
    logic [3:0] ev;
    cfg_addr_en = ae; cfg_class_en = ce; cfg_irq_en = ie;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_data = frame_byte(da, i); rx_crc_ok = crc; rx_da_hash = h;
      @(negedge clk);
      if (buf_valid) begin
        bc++;
        if (buf_data !== frame_byte(da, i)) bad++;
      end
    end
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 0;
    // expected values from the requirements
    full = (len >= 6);
    runt = (len < MIN_L);
    lng  = (len > MAX_L);
    kind = !full ? 0 : (da == '1) ? 2 : da[0] ? 1 : 0;
    hit  = TBL[h];
    pass = ae[4] | (full & ((ae[0] & kind == 0 & da == IA) | (ae[1] & kind == 0 & hit) |
                            (ae[2] & kind == 1 & hit) | (ae[3] & kind == 2)));
    ev   = {lng, runt, !crc, crc & !runt & !lng};
    cls  = ((ev & ~ce) == 4'd0);
    acc  = pass & cls;
    irq  = pass & (|(ev & ie));
    chk("R2", "frm_done", int'(frm_done), 1);
    chk("R3", "frm_kind", int'(frm_kind), kind);
    chk("R4-7/R12", "frm_addr_pass", int'(frm_addr_pass), int'(pass));
    chk("R8", "frm_runt", int'(frm_runt), int'(runt));
    chk("R8", "frm_long", int'(frm_long), int'(lng));
    chk("R8", "frm_crc_bad", int'(frm_crc_bad), int'(!crc));
    chk("R9", "frm_accept", int'(frm_accept), int'(acc));
    chk("R11", "frm_irq", int'(frm_irq), int'(irq));
    chk("R10", "buf_count", bc, (len < MAX_L) ? len : MAX_L);
    chk("R10", "buf_data_mismatch", bad, 0);
    @(negedge clk);
    chk("R2", "done_pulse_end", int'(frm_done | frm_accept | frm_irq), 0);
    chk("R2", "kind_held", int'(frm_kind), kind);
  endtask

  initial begin
    logic [47:0] pats [4];
    pats[0] = IA;
    pats[1] = IA ^ 48'h0000_0000_0100;
    pats[2] = 48'h0000_5E00_0001;
    pats[3] = '1;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "outs_in_reset", int'({frm_done, frm_accept, frm_irq, buf_valid}), 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "outs_after_reset", int'({frm_done, frm_accept, frm_irq, buf_valid}), 0);
    // address sweep: R3 R4 R5 R6 R7
    for (int p = 0; p < 4; p++)
      for (int ae = 0; ae < 32; ae++)
        for (int h = 0; h < 2; h++)
          run_frame(pats[p], 10, 1'b1, HW'(h), 5'(ae), 4'hF, 4'hF);
    // length / class sweep: R8 R9 R10 R11 R12
    for (int len = 1; len <= 15; len++)
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < 16; k++)
          run_frame(pats[3], len, c[0], HW'(0), k[0] ? 5'b10000 : 5'b01000,
                    4'(k), 4'(k) ^ 4'b0101);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule